// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Level

This block models every I/O device that shares one interrupt priority level. Each device has its own node. A node holds a request flip-flop. While that flip-flop is set, the node pulls a shared active-low request line low. Several nodes may request at once, and the line simply stays low.

When the hub answers with an acknowledge, the acknowledge enters node 0, which is the node nearest the processor, and ripples towards the tail. A node that is not requesting forwards the acknowledge. The first requesting node it reaches absorbs it, holds it and places its own vector on a shared data bus. Position in the chain is therefore the only priority among devices on the same level.

Each node runs a four-state machine:
- `ND_IDLE`: not requesting, no acknowledge seen.
- `ND_REQ`: request flip-flop set.
- `ND_PASS`: forwarding an acknowledge that arrived while idle.
- `ND_HOLD`: holding a captured acknowledge and driving its vector.

The transitions are:
- Idle goes to Req on a raise.
- Idle goes to Pass on an arriving acknowledge.
- Req goes to Hold on an arriving acknowledge.
- Pass returns to Idle or Req when the acknowledge falls.
- Hold returns to Idle or Req when the acknowledge falls.

A raise that arrives while a node is in Pass or Hold is recorded in a deferred flag. That flag routes the node to Req once the acknowledge falls.

Top module: `irq_chain_level`

## Requirements
- R1: Reset is asynchronous and active low. While reset is asserted, and after it is released with no activity, every node is idle. In that state `irq_line_n` is 1, `vec_data` is 0 and `ack_tail` equals `ack_in`.
- R2: A pulse on `dev_raise[i]` while the acknowledge is low sets node i's request on the next clock edge. From that edge on, `irq_line_n` reads 0.
- R3: `irq_line_n` reads 0 while one or more nodes request or hold, and 1 once none do. Simultaneous requesters leave the line at 0.
- R4: With no node requesting or holding, `ack_tail` follows `ack_in` in the same cycle, through combinational logic.
- R5: The requesting node with the lowest index that sees the acknowledge captures it on the next edge. While any node holds the acknowledge, `ack_tail` is 0, and nodes downstream of the holder keep their requests.
- R6: From the edge after node i captures the acknowledge until it releases it, `vec_data` equals `VEC_BASE + i*VEC_STEP`. With the defaults this gives 0x40, 0x44, 0x48 and 0x4C for nodes 0 to 3. At most one node drives the bus, and the bus reads 0 when no node holds.
- R7: On the first clock edge with `ack_in` low, the holding node clears its request flip-flop. `irq_line_n` returns to 1 if no other node requests.
- R8: A raise that reaches a node while it is passing or holding the acknowledge does not capture that acknowledge. The passing node keeps forwarding it. After the acknowledge falls, the node enters the requesting state.
- R9: Repeated raises while a node already requests produce a single request. After one capture and release, the line is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_raise | input | N | Per-device pulse that sets its request flip-flop |
| ack_in | input | 1 | Acknowledge from the hub into node 0 (active high) |
| irq_line_n | output | 1 | Shared active-low request line (wired-AND of all nodes) |
| ack_tail | output | 1 | Acknowledge leaving the last node |
| vec_data | output | VW | Shared vector bus, OR of the holder's vector |

## Verification
Two functions can fall in the same cycle: a device's raise and the arrival of the acknowledge at that device. The bench provokes this in three ways. It raises a passing node while the acknowledge is high. It raises a holding node before release. It raises a node downstream of an active holder. In each case it checks that the tail, the vector bus and the line show that the acknowledge stayed where it was decided. It also checks that the late request is served only after the acknowledge falls.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    typedef enum logic [1:0] {
        ND_IDLE = 2'd0,
        ND_REQ  = 2'd1,
        ND_PASS = 2'd2,
        ND_HOLD = 2'd3
    } node_state_e;

    // Vector owned by chain position idx
    function automatic logic [31:0] node_vector(input int idx, input int base, input int step);
        return 32'(base + idx * step);
    endfunction

endpackage

// File: rtl/irq_chain_node.sv
module irq_chain_node
    import irq_chain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic ack_up,
    output logic ack_down,
    output logic pull_low,
    output logic holding
);

    node_state_e state_q, state_d;
    logic        defer_q, defer_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ND_IDLE;
            defer_q <= 1'b0;
        end else begin
            state_q <= state_d;
            defer_q <= defer_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        defer_d = defer_q;
        unique case (state_q)
            ND_IDLE: begin
                if (ack_up) begin
                    state_d = ND_PASS;      // decision frozen: forward
                    defer_d = raise;
                end else if (raise) begin
                    state_d = ND_REQ;
                end
            end
            ND_REQ: begin
                if (ack_up) state_d = ND_HOLD;
            end
            ND_PASS, ND_HOLD: begin
                if (raise) defer_d = 1'b1;
                if (!ack_up) begin
                    state_d = (defer_q || raise) ? ND_REQ : ND_IDLE;
                    defer_d = 1'b0;
                end
            end
            default: state_d = ND_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        ack_down = 1'b0;
        pull_low = 1'b0;
        holding  = 1'b0;
        unique case (state_q)
            ND_IDLE, ND_PASS: ack_down = ack_up;
            ND_REQ:           pull_low = 1'b1;
            ND_HOLD: begin
                pull_low = 1'b1;
                holding  = 1'b1;
            end
            default: ack_down = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_wired_and.sv
module irq_wired_and #(
    parameter int N = 4
) (
    input  logic [N-1:0] pull_low,
    output logic         line_n
);

    // Each node acts as an open-drain switch on a pulled-up line
    logic [N:0] level;
    assign level[0] = 1'b1;

    for (genvar g = 0; g < N; g++) begin : g_drain
        assign level[g+1] = level[g] & ~pull_low[g];
    end

    assign line_n = level[N];

endmodule

// File: rtl/irq_vec_bus.sv
module irq_vec_bus
    import irq_chain_pkg::*;
#(
    parameter int N        = 4,
    parameter int VW       = 8,
    parameter int VEC_BASE = 'h40,
    parameter int VEC_STEP = 4
) (
    input  logic [N-1:0]  drive_en,
    output logic [VW-1:0] bus
);

    logic [VW-1:0] lane [N];

    for (genvar g = 0; g < N; g++) begin : g_lane
        localparam logic [31:0] VEC_FULL = node_vector(g, VEC_BASE, VEC_STEP);
        localparam logic [VW-1:0] VEC = VEC_FULL[VW-1:0];
        assign lane[g] = drive_en[g] ? VEC : '0;
    end

    always_comb begin
        bus = '0;
        for (int k = 0; k < N; k++) bus = bus | lane[k];
    end

endmodule

// File: rtl/irq_chain_level.sv
module irq_chain_level #(
    parameter int N        = 4,
    parameter int VW       = 8,
    parameter int VEC_BASE = 'h40,
    parameter int VEC_STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  dev_raise,
    input  logic          ack_in,
    output logic          irq_line_n,
    output logic          ack_tail,
    output logic [VW-1:0] vec_data
);

    logic [N:0]   ack_chain;
    logic [N-1:0] pull_vec;
    logic [N-1:0] hold_vec;

    assign ack_chain[0] = ack_in;

    for (genvar g = 0; g < N; g++) begin : g_node
        irq_chain_node node_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .raise    (dev_raise[g]),
            .ack_up   (ack_chain[g]),
            .ack_down (ack_chain[g+1]),
            .pull_low (pull_vec[g]),
            .holding  (hold_vec[g])
        );
    end

    assign ack_tail = ack_chain[N];

    irq_wired_and #(.N(N)) line_i (
        .pull_low (pull_vec),
        .line_n   (irq_line_n)
    );

    irq_vec_bus #(.N(N), .VW(VW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) bus_i (
        .drive_en (hold_vec),
        .bus      (vec_data)
    );

endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
    parameter int N  = 4,
    parameter int VW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack_in,
    input logic          ack_tail,
    input logic          irq_line_n,
    input logic [VW-1:0] vec_data,
    input logic [N-1:0]  hold_vec
);

    p_single_holder_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hold_vec));

    p_bus_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vec == '0) |-> (vec_data == '0));

    p_free_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in && irq_line_n) |-> ack_tail);

    p_holder_absorbs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vec != '0) |-> !ack_tail);

    p_holder_pulls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vec != '0) |-> !irq_line_n);

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vec != '0 && !ack_in) |=> (hold_vec == '0));

endmodule

bind irq_chain_level irq_chain_chk #(.N(N), .VW(VW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_in     (ack_in),
    .ack_tail   (ack_tail),
    .irq_line_n (irq_line_n),
    .vec_data   (vec_data),
    .hold_vec   (hold_vec)
);

// File: tb/irq_chain_level_tb.sv
`timescale 1ns/1ps
module irq_chain_level_tb_top;

    localparam int N  = 4;
    localparam int VW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  dev_raise = '0;
    logic          ack_in = 1'b0;
    logic          irq_line_n;
    logic          ack_tail;
    logic [VW-1:0] vec_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_chain_level #(.N(N), .VW(VW), .VEC_BASE('h40), .VEC_STEP(4)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_raise  (dev_raise),
        .ack_in     (ack_in),
        .irq_line_n (irq_line_n),
        .ack_tail   (ack_tail),
        .vec_data   (vec_data)
    );

    task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Row fields: req tag[3:0], raise[3:0], ack, exp line, exp tail, exp vec[7:0]
    localparam int ROWS = 31;
    localparam logic [18:0] TBL [ROWS] = '{
        {4'd1, 4'b0000, 1'b0, 1'b1, 1'b0, 8'h00}, // R1 idle
        {4'd4, 4'b0000, 1'b1, 1'b1, 1'b1, 8'h00}, // R4 free pass
        {4'd4, 4'b0000, 1'b0, 1'b1, 1'b0, 8'h00},
        {4'd2, 4'b0100, 1'b0, 1'b0, 1'b0, 8'h00}, // R2 node2 raises
        {4'd3, 4'b1000, 1'b0, 1'b0, 1'b0, 8'h00}, // R3 two requesters
        {4'd5, 4'b0000, 1'b1, 1'b0, 1'b0, 8'h48}, // R5 node2 captures
        {4'd6, 4'b0000, 1'b1, 1'b0, 1'b0, 8'h48}, // R6 held vector
        {4'd7, 4'b0000, 1'b0, 1'b0, 1'b0, 8'h00}, // R7 node2 releases, node3 still low
        {4'd6, 4'b0000, 1'b1, 1'b0, 1'b0, 8'h4C}, // R6 node3 captures
        {4'd7, 4'b0000, 1'b0, 1'b1, 1'b0, 8'h00}, // R7 line released
        {4'd2, 4'b0001, 1'b0, 1'b0, 1'b0, 8'h00},
        {4'd6, 4'b0000, 1'b1, 1'b0, 1'b0, 8'h40},
        {4'd5, 4'b0010, 1'b1, 1'b0, 1'b0, 8'h40}, // R5 downstream raise under holder
        {4'd7, 4'b0000, 1'b0, 1'b0, 1'b0, 8'h00},
        {4'd6, 4'b0000, 1'b1, 1'b0, 1'b0, 8'h44},
        {4'd3, 4'b0000, 1'b0, 1'b1, 1'b0, 8'h00},
        {4'd4, 4'b0000, 1'b1, 1'b1, 1'b1, 8'h00},
        {4'd8, 4'b0100, 1'b1, 1'b1, 1'b1, 8'h00}, // R8 raise while passing
        {4'd8, 4'b0000, 1'b0, 1'b0, 1'b0, 8'h00},
        {4'd8, 4'b0000, 1'b1, 1'b0, 1'b0, 8'h48},
        {4'd8, 4'b0000, 1'b0, 1'b1, 1'b0, 8'h00},
        {4'd9, 4'b0001, 1'b0, 1'b0, 1'b0, 8'h00}, // R9 repeated raise
        {4'd9, 4'b0001, 1'b0, 1'b0, 1'b0, 8'h00},
        {4'd9, 4'b0000, 1'b1, 1'b0, 1'b0, 8'h40},
        {4'd9, 4'b0000, 1'b0, 1'b1, 1'b0, 8'h00},
        {4'd2, 4'b0001, 1'b0, 1'b0, 1'b0, 8'h00},
        {4'd6, 4'b0000, 1'b1, 1'b0, 1'b0, 8'h40},
        {4'd8, 4'b0001, 1'b1, 1'b0, 1'b0, 8'h40}, // R8 raise while holding
        {4'd8, 4'b0000, 1'b0, 1'b0, 1'b0, 8'h00},
        {4'd8, 4'b0000, 1'b1, 1'b0, 1'b0, 8'h40},
        {4'd7, 4'b0000, 1'b0, 1'b1, 1'b0, 8'h00}
    };

    initial begin
        #1;
        chk(1, "line in reset", 32'(irq_line_n), 32'd1);   // R1
        chk(1, "vec in reset", 32'(vec_data), 32'd0);
        ack_in = 1'b1;
        #1;
        chk(1, "tail follows ack in reset", 32'(ack_tail), 32'd1);
        ack_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        for (int r = 0; r < ROWS; r++) begin
            @(negedge clk);
            dev_raise = TBL[r][14:11];
            ack_in    = TBL[r][10];
            @(posedge clk);
            #1;
            chk(int'(TBL[r][18:15]), $sformatf("row %0d line", r), 32'(irq_line_n), 32'(TBL[r][9]));
            chk(int'(TBL[r][18:15]), $sformatf("row %0d tail", r), 32'(ack_tail), 32'(TBL[r][8]));
            chk(int'(TBL[r][18:15]), $sformatf("row %0d vec", r), 32'(vec_data), 32'(TBL[r][7:0]));
        end

        // R4: same-cycle combinational pass before any edge
        @(negedge clk);
        dev_raise = '0;
        ack_in = 1'b1;
        #1;
        chk(4, "tail same cycle", 32'(ack_tail), 32'd1);
        @(negedge clk);
        ack_in = 1'b0;

        // R5: requester blocks the tail in the arrival cycle
        @(negedge clk);
        dev_raise = 4'b0010;
        @(negedge clk);
        dev_raise = '0;
        ack_in = 1'b1;
        #1;
        chk(5, "tail blocked by requester", 32'(ack_tail), 32'd0);
        @(posedge clk);
        #1;
        chk(6, "node1 vector", 32'(vec_data), 32'h44);

        // R1: reset while holding
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(1, "line after reset", 32'(irq_line_n), 32'd1);
        chk(1, "vec after reset", 32'(vec_data), 32'd0);
        chk(1, "tail after reset", 32'(ack_tail), 32'd1);
        @(negedge clk);
        ack_in = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(1, "idle after reset", 32'(irq_line_n), 32'd1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule